// File: doc/BRIEF.md
# Side-Effect Control Register File

A bank of 32-bit control registers for a command processor. Registers are written and read by index through one write port and one read port. Most writes only store the value. Two registers are write-triggered indirect ports. A write to the table data register goes on to a jump table. A write to the bus data register goes on to an external register bus. In both cases the target location comes from a companion address register, and that address register then advances by one.

The indirect writes leave the block combinationally, in the same cycle as the control write strobe. The address register advances at that clock edge, so back-to-back data writes reach consecutive locations. The bus address register has two halves. The low 16 bits are the offset. The high 16 bits are flags that the advance leaves untouched. A jump-table index outside the table is refused and raises a sticky error. A bus offset outside the implemented range is dropped without any error.

Top module: `cp_ctl_regfile`

## Requirements
- R1: A write (`cw_en`=1) stores `cw_data` in register `cw_idx`, and a later read of that index returns it.
- R2: Every write sets bit `cw_idx` of `cw_written`. The bit stays set until reset.
- R3: A write to the table data register (index 3) raises `jt_we` in the same cycle. `jt_addr` is the low bits of the table index register (index 2) and `jt_wdata` is `cw_data`.
- R4: After each write to the table data register, the table index register holds its previous value plus one. Back-to-back writes each advance it once.
- R5: If the table index is at or beyond `JT_DEPTH`, a table data write leaves `jt_we` low and sets `jt_err`. `jt_err` stays set until reset. The index still advances.
- R6: A write to the bus data register (index 5) raises `rb_we` in the same cycle. `rb_addr` is bits [15:0] of the bus address register (index 4) and `rb_wdata` is `cw_data`.
- R7: After each bus data write, bits [15:0] of the bus address register increase by one, wrapping within 16 bits. Bits [31:16] are unchanged.
- R8: A bus data write with an offset at or above `RB_RANGE` produces no `rb_we`. The offset still advances.
- R9: With `rd_en`=1, `rd_data` shows register `rd_idx` one clock later. If that register is written in the same cycle, the value returned is the one from before the write. Without `rd_en`, `rd_data` holds.
- R10: After reset, all registers, `cw_written`, `rd_data` and `jt_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_en | input | 1 | Control register write strobe |
| cw_idx | input | 4 | Control register write index |
| cw_data | input | 32 | Control register write value |
| rd_en | input | 1 | Read request |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read value, one cycle after request |
| cw_written | output | 16 | Per-register written flags |
| jt_we | output | 1 | Jump-table write strobe |
| jt_addr | output | 5 | Jump-table write index |
| jt_wdata | output | 32 | Jump-table write value |
| jt_err | output | 1 | Sticky out-of-range table index flag |
| rb_we | output | 1 | External register bus write strobe |
| rb_addr | output | 16 | External register bus offset |
| rb_wdata | output | 32 | External register bus write value |

## Verification
The jump-table and register-bus strobes, addresses and data are due in the same cycle as the write strobe. The bench drives inputs on the falling edge and compares these outputs shortly afterwards, before the next rising edge. Stored values, written flags, the error flag and read data are due one rising edge after the request. They are compared just after that edge against a behavioural model, which captures the read value before it applies the same cycle's write.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned OFS_W   = 16;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/ctlrf_bank.sv
module ctlrf_bank #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned TIDX_REG  = 2,
   parameter int unsigned BADR_REG  = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tidx_adv,
   input  logic [DATA_W-1:0] tidx_next,
   input  logic              badr_adv,
   input  logic [DATA_W-1:0] badr_next,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_REGS-1:0] written,
   output logic [DATA_W-1:0] tidx_q,
   output logic [DATA_W-1:0] badr_q
);
   logic [DATA_W-1:0]   regs_q [NUM_REGS];
   logic [NUM_REGS-1:0] written_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
         written_q <= '0;
      end else begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
               regs_q[i]    <= wr_data;
               written_q[i] <= 1'b1;
            end else if (i == int'(TIDX_REG) && tidx_adv) begin
               regs_q[i] <= tidx_next;
            end else if (i == int'(BADR_REG) && badr_adv) begin
               regs_q[i] <= badr_next;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= regs_q[rd_idx];
   end

   assign written = written_q;
   assign tidx_q  = regs_q[TIDX_REG];
   assign badr_q  = regs_q[BADR_REG];

   // R9: read data one cycle later, value before any same-cycle write
   p_rd_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_data == $past(regs_q[rd_idx]));

   // R9: rd_data holds without a request
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag_chk
         // R2: written flags are sticky
         p_written_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            written_q[g] |=> written_q[g]);
      end
   endgenerate
endmodule

// File: rtl/ctlrf_tbl_port.sv
module ctlrf_tbl_port #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned JT_DEPTH = 32,
   localparam int unsigned JT_AW   = (JT_DEPTH > 1) ? $clog2(JT_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] idx_q,
   output logic              jt_we,
   output logic [JT_AW-1:0]  jt_addr,
   output logic [DATA_W-1:0] idx_next,
   output logic              err
);
   logic in_range;
   logic err_q;

   assign in_range = idx_q < DATA_W'(JT_DEPTH);
   assign jt_we    = hit && in_range;
   assign jt_addr  = idx_q[JT_AW-1:0];
   assign idx_next = idx_q + DATA_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)                err_q <= 1'b0;
      else if (hit && !in_range) err_q <= 1'b1;
   end
   assign err = err_q;

   // R4: each table data write advances the index once
   p_idx_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> idx_q == $past(idx_q) + DATA_W'(1));

   // R5: error flag is sticky
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/ctlrf_bus_port.sv
module ctlrf_bus_port #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned RB_RANGE = 4096,
   localparam int unsigned OFS_W   = ctlrf_pkg::OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] adr_q,
   output logic              rb_we,
   output logic [OFS_W-1:0]  rb_addr,
   output logic [DATA_W-1:0] adr_next
);
   logic [OFS_W-1:0] ofs;
   logic             in_range;

   assign ofs      = adr_q[OFS_W-1:0];
   assign in_range = {1'b0, ofs} < (OFS_W+1)'(RB_RANGE);
   assign rb_we    = hit && in_range;
   assign rb_addr  = ofs;
   assign adr_next = {adr_q[DATA_W-1:OFS_W], ofs + OFS_W'(1)};

   // R7: offset advances within 16 bits, flag half kept
   p_flags_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (adr_q[DATA_W-1:OFS_W] == $past(adr_q[DATA_W-1:OFS_W]))
           && (adr_q[OFS_W-1:0] == $past(adr_q[OFS_W-1:0]) + OFS_W'(1)));
endmodule

// File: rtl/cp_ctl_regfile.sv
module cp_ctl_regfile #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned JT_DEPTH  = 32,
   parameter int unsigned RB_RANGE  = 4096,
   parameter int unsigned TIDX_REG  = 2,
   parameter int unsigned TDAT_REG  = 3,
   parameter int unsigned BADR_REG  = 4,
   parameter int unsigned BDAT_REG  = 5,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS),
   localparam int unsigned JT_AW    = (JT_DEPTH > 1) ? $clog2(JT_DEPTH) : 1,
   localparam int unsigned OFS_W    = ctlrf_pkg::OFS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cw_en,
   input  logic [IDX_W-1:0]    cw_idx,
   input  logic [DATA_W-1:0]   cw_data,
   input  logic                rd_en,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data,
   output logic [NUM_REGS-1:0] cw_written,
   output logic                jt_we,
   output logic [JT_AW-1:0]    jt_addr,
   output logic [DATA_W-1:0]   jt_wdata,
   output logic                jt_err,
   output logic                rb_we,
   output logic [OFS_W-1:0]    rb_addr,
   output logic [DATA_W-1:0]   rb_wdata
);
   generate
      if (DATA_W != ctlrf_pkg::WORD_W) begin : g_bad_width
         initial $fatal(1, "DATA_W must equal the package word width");
      end
      if (!ctlrf_pkg::is_pow2(NUM_REGS) || NUM_REGS < 8) begin : g_bad_regs
         initial $fatal(1, "NUM_REGS must be a power of two of at least 8");
      end
      if (!ctlrf_pkg::is_pow2(JT_DEPTH)) begin : g_bad_depth
         initial $fatal(1, "JT_DEPTH must be a power of two");
      end
      if (RB_RANGE == 0 || RB_RANGE > (1 << OFS_W)) begin : g_bad_range
         initial $fatal(1, "RB_RANGE out of offset space");
      end
      if (TIDX_REG >= NUM_REGS || TDAT_REG >= NUM_REGS ||
          BADR_REG >= NUM_REGS || BDAT_REG >= NUM_REGS ||
          TIDX_REG == TDAT_REG || BADR_REG == BDAT_REG ||
          TIDX_REG == BADR_REG || TDAT_REG == BDAT_REG) begin : g_bad_map
         initial $fatal(1, "special register indices invalid");
      end
   endgenerate

   logic              tbl_hit, bus_hit;
   logic [DATA_W-1:0] tidx_q, tidx_next, badr_q, badr_next;

   assign tbl_hit = cw_en && (cw_idx == IDX_W'(TDAT_REG));
   assign bus_hit = cw_en && (cw_idx == IDX_W'(BDAT_REG));

   ctlrf_bank #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
      .TIDX_REG(TIDX_REG), .BADR_REG(BADR_REG)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cw_en), .wr_idx(cw_idx), .wr_data(cw_data),
      .tidx_adv(tbl_hit), .tidx_next(tidx_next),
      .badr_adv(bus_hit), .badr_next(badr_next),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
      .written(cw_written), .tidx_q(tidx_q), .badr_q(badr_q)
   );

   ctlrf_tbl_port #(.DATA_W(DATA_W), .JT_DEPTH(JT_DEPTH)) u_tbl (
      .clk(clk), .rst_n(rst_n), .hit(tbl_hit), .idx_q(tidx_q),
      .jt_we(jt_we), .jt_addr(jt_addr), .idx_next(tidx_next), .err(jt_err)
   );

   ctlrf_bus_port #(.DATA_W(DATA_W), .RB_RANGE(RB_RANGE)) u_bus (
      .clk(clk), .rst_n(rst_n), .hit(bus_hit), .adr_q(badr_q),
      .rb_we(rb_we), .rb_addr(rb_addr), .adr_next(badr_next)
   );

   assign jt_wdata = cw_data;
   assign rb_wdata = cw_data;

   // R8: a bus strobe never carries an offset outside the range
   p_bus_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rb_we |-> ({1'b0, rb_addr} < (OFS_W+1)'(RB_RANGE)));

   // R3, R6: at most one indirect strobe per cycle, only with a write
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (jt_we || rb_we) |-> (cw_en && $countones({jt_we, rb_we}) == 1));
endmodule

// File: tb/cp_ctl_regfile_tb.sv
module cp_ctl_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cw_en = 1'b0;
   logic [3:0]  cw_idx = '0;
   logic [31:0] cw_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic [15:0] cw_written;
   logic        jt_we;
   logic [4:0]  jt_addr;
   logic [31:0] jt_wdata;
   logic        jt_err;
   logic        rb_we;
   logic [15:0] rb_addr;
   logic [31:0] rb_wdata;

   always #5 clk = ~clk;

   cp_ctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .cw_written(cw_written),
      .jt_we(jt_we), .jt_addr(jt_addr), .jt_wdata(jt_wdata), .jt_err(jt_err),
      .rb_we(rb_we), .rb_addr(rb_addr), .rb_wdata(rb_wdata)
   );

   int n_vec = 0;
   int n_bad = 0;

   logic [31:0] m_reg [16];
   logic [15:0] m_wr;
   logic        m_err;
   logic [31:0] m_rd;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      m_wr = '0; m_err = 1'b0; m_rd = '0;
   endtask

   task automatic cyc(input bit we, input int widx, input logic [31:0] wd,
                      input bit re, input int ridx);
      bit          e_jwe, e_rwe;
      @(negedge clk);
      cw_en = we; cw_idx = 4'(widx); cw_data = wd;
      rd_en = re; rd_idx = 4'(ridx);
      #1;
      // R3/R5: same-cycle jump-table strobe
      e_jwe = we && widx == 3 && m_reg[2] < 32;
      chk("R3/R5", "jt_we", 32'(jt_we), 32'(e_jwe));
      if (e_jwe) begin
         chk("R3", "jt_addr", 32'(jt_addr), 32'(m_reg[2][4:0]));
         chk("R3", "jt_wdata", jt_wdata, wd);
      end
      // R6/R8: same-cycle bus strobe
      e_rwe = we && widx == 5 && m_reg[4][15:0] < 16'd4096;
      chk("R6/R8", "rb_we", 32'(rb_we), 32'(e_rwe));
      if (e_rwe) begin
         chk("R6", "rb_addr", 32'(rb_addr), 32'(m_reg[4][15:0]));
         chk("R6", "rb_wdata", rb_wdata, wd);
      end
      @(posedge clk);
      #1;
      if (re) m_rd = m_reg[ridx];
      if (we) begin
         m_reg[widx] = wd;
         m_wr[widx]  = 1'b1;
         if (widx == 3) begin
            if (m_reg[2] >= 32) m_err = 1'b1;
            m_reg[2] = m_reg[2] + 1;
         end
         if (widx == 5) m_reg[4] = {m_reg[4][31:16], m_reg[4][15:0] + 16'd1};
      end
      chk("R9", "rd_data", rd_data, m_rd);
      chk("R2", "cw_written", 32'(cw_written), 32'(m_wr));
      chk("R5", "jt_err", 32'(jt_err), 32'(m_err));
   endtask

   task automatic wr(input int idx, input logic [31:0] d);
      cyc(1'b1, idx, d, 1'b0, 0);
   endtask

   task automatic rd(input int idx);
      cyc(1'b0, 0, '0, 1'b1, idx);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R10: reset state
      chk("R10", "rd_data", rd_data, '0);
      chk("R10", "cw_written", 32'(cw_written), '0);
      chk("R10", "jt_err", 32'(jt_err), '0);
      rd(7);
      rd(2);

      // R1: plain stores with read-back
      wr(0, 32'hDEAD_BEEF);
      wr(1, 32'h0000_0001);
      wr(15, 32'hA5A5_5A5A);
      for (int i = 8; i < 12; i++) wr(i, 32'h1000_0000 * i + 32'h33);
      rd(0); rd(1); rd(15); rd(9); rd(12);

      // R9: read and write of the same register in one cycle
      cyc(1'b1, 9, 32'h0BAD_F00D, 1'b1, 9);
      rd(9);
      cyc(1'b0, 0, '0, 1'b0, 0);

      // R3/R4: table writes, back-to-back, then past the end (R5)
      wr(2, 32'd29);
      wr(3, 32'h1111_0001);
      wr(3, 32'h1111_0002);
      wr(3, 32'h1111_0003);
      rd(2);
      wr(3, 32'h1111_0004);
      rd(2); rd(3);
      wr(2, 32'd0);
      wr(3, 32'h2222_0000);
      cyc(1'b1, 3, 32'h2222_0001, 1'b1, 2);
      rd(2);

      // R6/R7/R8: bus writes with flags, range edge
      wr(4, 32'hABCD_0FFE);
      wr(5, 32'h5555_0001);
      wr(5, 32'h5555_0002);
      wr(5, 32'h5555_0003);
      rd(4);
      // R7: 16-bit wrap keeps flags
      wr(4, 32'h1234_FFFF);
      wr(5, 32'h6666_0000);
      wr(5, 32'h6666_0001);
      rd(4); rd(5);
      // interleaved table and bus writes
      wr(3, 32'h7777_0000);
      wr(5, 32'h7777_0001);
      wr(3, 32'h7777_0002);
      rd(2); rd(4);

      // R10: reset in the middle clears everything
      @(negedge clk); rst_n = 1'b0; cw_en = 1'b0; rd_en = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      model_reset();
      chk("R10", "jt_err", 32'(jt_err), '0);
      chk("R10", "cw_written", 32'(cw_written), '0);
      rd(4);
      wr(3, 32'hFEED_0000);
      rd(2);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule